// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This block resolves read-after-write register dependencies for an in-order scalar pipeline with six stages: fetch, decode, operand read, ALU, memory and write-back. It looks at the two source register numbers of the instruction now reading operands. It compares them with the destination register, write enable and load flag of the three older instructions in the ALU, memory and write-back stages. With this stage order, write-after-read and write-after-write conflicts cannot happen, so the block checks only read-after-write.

For each source operand the block drives a two-bit mux select. The select takes the register file value or bypasses a result from one of the three older stages. If more than one older stage writes the same register, the youngest writer wins. A load in the ALU stage has no data until the memory stage finishes, so bypassing cannot cover it. In that case the block raises, in the same cycle and without a register, three interlock strobes. The strobes hold the program counter, hold the fetch/decode latch and insert a bubble. Downstream logic uses the bubble strobe to clear every write enable of the inserted slot. The block has no clock and no state.

Top module: `hazard_fwd_unit`

## Requirements
- R1: When no older stage matches a source, that source's select is 00, the register file value.
- R2: A source that matches the ALU-stage destination, with its write enable high, gets select 01.
- R3: A source that matches only the memory-stage destination, with its write enable high, gets select 10.
- R4: A source that matches only the write-back-stage destination, with its write enable high, gets select 11.
- R5: When several older stages match one source, the youngest wins: ALU (01) over memory (10) over write-back (11).
- R6: A source register number of 0 never matches, so its select is always 00 and it never causes a stall.
- R7: A producer whose write enable is low never matches any source, even when its destination number is equal.
- R8: A load in the ALU stage with write enable high, whose nonzero destination equals either source, raises holdPc, holdIfId and bubble in the same cycle.
- R9: A load in the memory or write-back stage never stalls; its result is bypassed with select 10 or 11.
- R10: The two source selects are computed independently; each follows R1 to R7 for its own register number.
- R11: When no stall condition holds, all three strobes are low. The three strobes always have the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcA | input | 5 | First source register number of the operand-read instruction |
| srcB | input | 5 | Second source register number of the operand-read instruction |
| aluDest | input | 5 | Destination register of the ALU-stage instruction |
| aluWe | input | 1 | ALU-stage instruction writes a register |
| aluLoad | input | 1 | ALU-stage instruction is a load |
| memDest | input | 5 | Destination register of the memory-stage instruction |
| memWe | input | 1 | Memory-stage instruction writes a register |
| wbDest | input | 5 | Destination register of the write-back-stage instruction |
| wbWe | input | 1 | Write-back-stage instruction writes a register |
| selA | output | 2 | Operand A select: 00 file, 01 ALU, 10 MEM, 11 WB |
| selB | output | 2 | Operand B select, same encoding |
| holdPc | output | 1 | Keep the program counter unchanged |
| holdIfId | output | 1 | Keep the fetch/decode latch unchanged |
| bubble | output | 1 | Insert a no-op with all write enables cleared |

## Verification
The hardest case to reach is a three-way tie. Here all three older stages write the same nonzero register that one source reads, and the ALU producer is a load, so priority and the interlock must agree. Uniform random register numbers almost never produce this. The stimulus therefore draws register numbers from a small pool of values, mostly 0 to 3, and adds directed vectors. The directed vectors stack equal destinations and flip the write enables and the load flag one at a time.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  parameter int REG_W    = 5;
  parameter int SRC_CNT  = 2;
  parameter int PROD_CNT = 3;              // 0 = ALU, 1 = MEM, 2 = WB
  localparam int SEL_W   = $clog2(PROD_CNT + 1);

  typedef enum logic [SEL_W-1:0] {
    SEL_FILE = 2'b00,
    SEL_ALU  = 2'b01,
    SEL_MEM  = 2'b10,
    SEL_WB   = 2'b11
  } fwdSel_e;

  // datapath -> control: which sources the youngest producer hits
  typedef struct packed {
    logic [SRC_CNT-1:0] aluHit;
  } matchInfo_t;

  // control -> pipeline: interlock strobes
  typedef struct packed {
    logic holdPc;
    logic holdIfId;
    logic bubble;
  } stallCtl_t;
endpackage

// File: rtl/fwd_path.sv
module fwd_path
  import hzd_pkg::*;
(
  input  logic [SRC_CNT-1:0][REG_W-1:0]  srcReg,
  input  logic [PROD_CNT-1:0][REG_W-1:0] prodDest,
  input  logic [PROD_CNT-1:0]            prodWe,
  output logic [SRC_CNT-1:0][SEL_W-1:0]  selVec,
  output matchInfo_t                     matchOut
);
  for (genvar s = 0; s < SRC_CNT; s++) begin : g_src
    logic [PROD_CNT-1:0] hit;

    for (genvar p = 0; p < PROD_CNT; p++) begin : g_prod
      assign hit[p] = prodWe[p] && (prodDest[p] == srcReg[s]) && (srcReg[s] != '0);
    end

    // scan oldest to youngest so the youngest hit is the last assignment
    always_comb begin
      selVec[s] = SEL_W'(SEL_FILE);
      for (int p = PROD_CNT - 1; p >= 0; p--) begin
        if (hit[p]) selVec[s] = SEL_W'(p + 1);
      end
    end

    assign matchOut.aluHit[s] = hit[0];

    always_comb begin
      assert_zero_reg_R6: assert (srcReg[s] != '0 || selVec[s] == SEL_W'(SEL_FILE));
      if (selVec[s] != SEL_W'(SEL_FILE))
        assert_we_gate_R7: assert (prodWe[selVec[s] - 1'b1]);
      if (selVec[s] == SEL_W'(SEL_MEM))
        assert_youngest_R5: assert (!(prodWe[0] && prodDest[0] == srcReg[s]));
    end
  end
endmodule

// File: rtl/stall_ctrl.sv
module stall_ctrl
  import hzd_pkg::*;
(
  input  matchInfo_t matchIn,
  input  logic       aluLoad,
  output stallCtl_t  ctl
);
  logic loadUse;

  assign loadUse      = aluLoad && (|matchIn.aluHit);
  assign ctl.holdPc   = loadUse;
  assign ctl.holdIfId = loadUse;
  assign ctl.bubble   = loadUse;

  always_comb begin
    if (!aluLoad)
      assert_no_stall_R11: assert (!ctl.bubble);
  end
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hzd_pkg::*;
(
  input  logic [4:0] srcA,
  input  logic [4:0] srcB,
  input  logic [4:0] aluDest,
  input  logic       aluWe,
  input  logic       aluLoad,
  input  logic [4:0] memDest,
  input  logic       memWe,
  input  logic [4:0] wbDest,
  input  logic       wbWe,
  output logic [1:0] selA,
  output logic [1:0] selB,
  output logic       holdPc,
  output logic       holdIfId,
  output logic       bubble
);
  logic [SRC_CNT-1:0][REG_W-1:0]  srcReg;
  logic [PROD_CNT-1:0][REG_W-1:0] prodDest;
  logic [PROD_CNT-1:0]            prodWe;
  logic [SRC_CNT-1:0][SEL_W-1:0]  selVec;
  matchInfo_t                     matchInfo;
  stallCtl_t                      ctl;

  assign srcReg   = {srcB, srcA};
  assign prodDest = {wbDest, memDest, aluDest};
  assign prodWe   = {wbWe, memWe, aluWe};

  fwd_path u_path (
    .srcReg   (srcReg),
    .prodDest (prodDest),
    .prodWe   (prodWe),
    .selVec   (selVec),
    .matchOut (matchInfo)
  );

  stall_ctrl u_ctrl (
    .matchIn (matchInfo),
    .aluLoad (aluLoad),
    .ctl     (ctl)
  );

  assign selA     = selVec[0];
  assign selB     = selVec[1];
  assign holdPc   = ctl.holdPc;
  assign holdIfId = ctl.holdIfId;
  assign bubble   = ctl.bubble;

  // cross-module: an interlock needs an ALU-stage bypass on some operand
  always_comb begin
    if (bubble)
      assert_load_use_R8: assert (aluLoad && aluWe && (selA == 2'b01 || selB == 2'b01));
  end
endmodule

// File: tb/sim_hazard_fwd_unit.sv
`timescale 1ns/1ps
module sim_hazard_fwd_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0] srcA, srcB, aluDest, memDest, wbDest;
  logic aluWe, aluLoad, memWe, wbWe;
  logic [1:0] selA, selB;
  logic holdPc, holdIfId, bubble;

  int checks = 0;
  int fails  = 0;

  hazard_fwd_unit u0 (
    .srcA(srcA), .srcB(srcB), .aluDest(aluDest), .aluWe(aluWe), .aluLoad(aluLoad),
    .memDest(memDest), .memWe(memWe), .wbDest(wbDest), .wbWe(wbWe),
    .selA(selA), .selB(selB), .holdPc(holdPc), .holdIfId(holdIfId), .bubble(bubble)
  );

  function automatic logic [1:0] refSel(input logic [4:0] s);
    if (s == 5'd0) return 2'b00;
    if (aluWe && aluDest == s) return 2'b01;
    if (memWe && memDest == s) return 2'b10;
    if (wbWe && wbDest == s) return 2'b11;
    return 2'b00;
  endfunction

  function automatic logic refStall();
    return aluLoad && aluWe && aluDest != 5'd0 && (aluDest == srcA || aluDest == srcB);
  endfunction

  task automatic drive(input logic [4:0] a, b, ad, input logic awe, ald,
                       input logic [4:0] md, input logic mwe,
                       input logic [4:0] wd, input logic wwe);
    @(posedge clk);
    srcA = a; srcB = b; aluDest = ad; aluWe = awe; aluLoad = ald;
    memDest = md; memWe = mwe; wbDest = wd; wbWe = wwe;
    @(negedge clk);
  endtask

  task automatic checkAll(input string req);
    logic [1:0] eA, eB;
    logic eS;
    eA = refSel(srcA); eB = refSel(srcB); eS = refStall();
    checks++;
    if (selA !== eA || selB !== eB || holdPc !== eS || holdIfId !== eS || bubble !== eS) begin
      fails++;
      $display("FAIL %s: got selA=%b selB=%b stall=%b%b%b, expected selA=%b selB=%b stall=%b",
               req, selA, selB, holdPc, holdIfId, bubble, eA, eB, eS);
    end
  endtask

  function automatic logic [4:0] pickReg();
    int unsigned r = $urandom % 8;
    if (r < 6) return 5'(r % 4);
    return 5'($urandom % 32);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd502));
    srcA = '0; srcB = '0; aluDest = '0; memDest = '0; wbDest = '0;
    aluWe = 0; aluLoad = 0; memWe = 0; wbWe = 0;
    @(negedge clk);
    checkAll("R1 idle");
    drive(5, 6, 7, 1, 0, 8, 1, 9, 1);  checkAll("R1 no match");
    drive(5, 6, 5, 1, 0, 8, 1, 9, 1);  checkAll("R2 alu bypass A");
    drive(5, 6, 7, 1, 0, 6, 1, 9, 1);  checkAll("R3 mem bypass B");
    drive(5, 6, 7, 1, 0, 8, 1, 5, 1);  checkAll("R4 wb bypass A");
    drive(4, 4, 4, 1, 0, 4, 1, 4, 1);  checkAll("R5 triple tie");
    drive(4, 3, 1, 1, 0, 4, 1, 4, 1);  checkAll("R5 mem over wb");
    drive(0, 0, 0, 1, 1, 0, 1, 0, 1);  checkAll("R6 zero reg");
    drive(5, 5, 5, 0, 1, 5, 0, 5, 1);  checkAll("R7 we low skips to wb");
    drive(5, 5, 5, 0, 0, 5, 0, 5, 0);  checkAll("R7 all we low");
    drive(2, 9, 2, 1, 1, 0, 0, 0, 0);  checkAll("R8 load-use A");
    drive(9, 2, 2, 1, 1, 2, 1, 2, 1);  checkAll("R8 load-use B triple");
    drive(2, 2, 3, 1, 1, 2, 1, 7, 1);  checkAll("R9 load in mem");
    drive(7, 3, 1, 1, 1, 2, 1, 7, 1);  checkAll("R9 load in wb");
    drive(3, 7, 3, 1, 0, 7, 1, 0, 0);  checkAll("R10 independent");
    drive(6, 6, 7, 1, 1, 6, 1, 6, 1);  checkAll("R11 load no match");
    for (int i = 0; i < 3000; i++) begin
      drive(pickReg(), pickReg(), pickReg(), 1'($urandom), 1'($urandom),
            pickReg(), 1'($urandom), pickReg(), 1'($urandom));
      checkAll("R10 random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule